// File: doc/BRIEF.md
# DMA Channel Request Detector

This block sits in front of one DMA channel engine and decides when that channel may start a transfer. It takes requests from one of two sources. The first is an asynchronous external request pin, which the block synchronises and then detects in one of four modes: low level, high level, falling edge or rising edge. The second is a one-cycle request strobe from an on-chip peripheral. A request is acted on only while the channel's enable conditions all hold. When one is accepted, the block drives a one-cycle transfer-request pulse to the engine.

After that pulse the block refuses further requests until the engine returns a one-cycle acknowledge. This keeps at most one request outstanding. In the two level modes a policy bit decides what happens to a request level that the requester has not yet withdrawn when the acknowledge arrives. With policy 0 that stale level is ignored for a guard window, so the number of transfers equals the number of requests. With policy 1 it is honoured once, which gives one trailing transfer.

Top module: `dmaReqDetect`

## Requirements
- R1: Detection mode code 2'b00 selects low-level detection. A low synchronised pin is a request. After reset the pin synchroniser holds the inactive (high) value.
- R2: Mode code 2'b01 selects falling-edge detection. A high-to-low change of the synchronised pin is one request, and holding the pin low produces no further request.
- R3: Mode code 2'b10 selects high-level detection. A high synchronised pin is a request.
- R4: Mode code 2'b11 selects rising-edge detection. A low-to-high change is one request, and holding the pin high produces no further request.
- R5: The external pin passes through SYNC_STAGES (default 2) flip-flops. A pin change driven between two rising clock edges appears on `xferReq` after the third rising edge that follows.
- R6: `xferReq` is high for exactly one clock cycle per accepted request.
- R7: After a request is accepted, no further request is accepted until `xferAck` is sampled high. An edge that occurs during this window is dropped, not queued. An acknowledge that arrives while no request is outstanding has no effect.
- R8: With `overrunSel` = 0 in a level mode, the level is ignored for GUARD_CYCLES (default 2) decision cycles after the acknowledge. A level withdrawn together with the acknowledge therefore causes no extra transfer, and a level still held afterwards is accepted on the next cycle.
- R9: With `overrunSel` = 1 in a level mode, the level is judged in the first cycle after the acknowledge. A level withdrawn together with the acknowledge therefore causes exactly one more transfer.
- R10: Requests are accepted only while `chanEn`=1, `masterEn`=1, `xferEnd`=0, `addrErr`=0 and `nmiFlag`=0. If any of these fails, the outstanding state is cleared on the next clock and no pulse is issued. Once all conditions hold again, a held level is accepted without an acknowledge.
- R11: With `srcPeriph`=1, each `periphReq` strobe sampled while acceptance is open produces `xferReq` after the next clock edge, and the external pin has no effect.
- R12: During and just after reset, `xferReq` is 0 and acceptance is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| detMode | input | 2 | Detection mode: 00 low level, 01 falling, 10 high level, 11 rising |
| overrunSel | input | 1 | Level-mode trailing-request policy (0 exact, 1 plus one) |
| srcPeriph | input | 1 | 1 selects the peripheral strobe, 0 the external pin |
| chanEn | input | 1 | Channel enable |
| masterEn | input | 1 | Master enable for all channels |
| xferEnd | input | 1 | Transfer-end flag, blocks requests when 1 |
| addrErr | input | 1 | Address-error flag, blocks requests when 1 |
| nmiFlag | input | 1 | NMI flag, blocks requests when 1 |
| extReq | input | 1 | Asynchronous external request pin |
| periphReq | input | 1 | Synchronous one-cycle peripheral request strobe |
| xferAck | input | 1 | One-cycle acknowledge from the channel engine |
| xferReq | output | 1 | One-cycle transfer-request pulse to the engine |

## Verification
A wrong internal state shows at `xferReq` and nowhere else. Two examples: an accept gate that stays closed turns into a missing pulse three cycles after a pin change, and a guard counter that is off by one turns into an extra or missing pulse in the cycle straight after an acknowledge. Stale edge history shows up as a pulse where the pin made no transition. Pending state that is not cleared shows up as a held level that goes unserved after the enables return. Every such fault is visible within a handful of cycles of the stimulus that exposes it, so the bench compares `xferReq` with an expected value on every cycle.

// File: rtl/dmaReqPkg.sv
package dmaReqPkg;

  typedef enum logic [1:0] {
    DET_LOW  = 2'b00,
    DET_FALL = 2'b01,
    DET_HIGH = 2'b10,
    DET_RISE = 2'b11
  } detMode_e;

  typedef struct packed {
    logic loadGuard;
    logic clearGuard;
  } ctrlStrobes_t;

endpackage

// File: rtl/dmaReqDatapath.sv
module dmaReqDatapath
  import dmaReqPkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int GUARD_CYCLES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [1:0]   detMode,
  input  logic         srcPeriph,
  input  logic         extReq,
  input  logic         periphReq,
  input  ctrlStrobes_t strb,
  output logic         hit,
  output logic         levelExt
);

  localparam int GW = $clog2(GUARD_CYCLES + 1);

  detMode_e          modeSel;
  logic [SYNC_STAGES-1:0] syncQ;
  logic              pinNow;
  logic              pinPrev;
  logic [GW-1:0]     guardCnt;
  logic              levelActive;
  logic              edgeHit;
  logic              extHit;

  assign modeSel = detMode_e'(detMode);

  // synchroniser chain, idle level is high (inactive for the default mode)
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ <= '1;
    end else begin
      syncQ[0] <= extReq;
      for (int i = 1; i < SYNC_STAGES; i++) syncQ[i] <= syncQ[i-1];
    end
  end

  assign pinNow = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rstN) pinPrev <= 1'b1;
    else       pinPrev <= pinNow;
  end

  // guard window after an acknowledge in exact-count level mode
  always_ff @(posedge clk) begin
    if (!rstN)                guardCnt <= '0;
    else if (strb.clearGuard) guardCnt <= '0;
    else if (strb.loadGuard)  guardCnt <= GW'(GUARD_CYCLES);
    else if (guardCnt != '0)  guardCnt <= guardCnt - GW'(1);
  end

  always_comb begin
    levelActive = 1'b0;
    edgeHit     = 1'b0;
    unique case (modeSel)
      DET_LOW:  levelActive = ~pinNow;
      DET_HIGH: levelActive = pinNow;
      DET_FALL: edgeHit     = pinPrev & ~pinNow;
      DET_RISE: edgeHit     = ~pinPrev & pinNow;
      default:  levelActive = 1'b0;
    endcase
  end

  assign levelExt = ~srcPeriph & ~detMode[0];
  assign extHit   = detMode[0] ? edgeHit : (levelActive && (guardCnt == '0));
  assign hit      = srcPeriph ? periphReq : extHit;

  // R8: a freshly loaded guard is nonzero on the following cycle
  p_guard_armed_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadGuard && !strb.clearGuard) |=> (guardCnt != '0));

endmodule

// File: rtl/dmaReqControl.sv
module dmaReqControl
  import dmaReqPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         overrunSel,
  input  logic         chanEn,
  input  logic         masterEn,
  input  logic         xferEnd,
  input  logic         addrErr,
  input  logic         nmiFlag,
  input  logic         hit,
  input  logic         levelExt,
  input  logic         xferAck,
  output ctrlStrobes_t strb,
  output logic         xferReq
);

  typedef enum logic {ST_OPEN = 1'b0, ST_WAIT = 1'b1} accState_e;

  accState_e state;
  logic      enableOk;
  logic      ackTaken;

  assign enableOk = chanEn & masterEn & ~xferEnd & ~addrErr & ~nmiFlag;
  assign ackTaken = enableOk && (state == ST_WAIT) && xferAck;

  always_comb begin
    strb.clearGuard = ~enableOk;
    strb.loadGuard  = ackTaken && levelExt && !overrunSel;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_OPEN;
      xferReq <= 1'b0;
    end else if (!enableOk) begin
      state   <= ST_OPEN;
      xferReq <= 1'b0;
    end else if (state == ST_OPEN) begin
      xferReq <= hit;
      if (hit) state <= ST_WAIT;
    end else begin
      xferReq <= 1'b0;
      if (xferAck) state <= ST_OPEN;
    end
  end

  // R6: request is a single-cycle pulse
  p_pulse_one_r6: assert property (@(posedge clk) disable iff (!rstN)
    xferReq |=> !xferReq);

  // R7: nothing new while a request waits for its acknowledge
  p_single_outstanding_r7: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_WAIT) && !xferAck) |=> !xferReq);

  // R7: acknowledge reopens acceptance
  p_ack_reopens_r7: assert property (@(posedge clk) disable iff (!rstN)
    ackTaken |=> (state == ST_OPEN));

  // R10: failing enable clears pending state and suppresses the pulse
  p_enable_drop_r10: assert property (@(posedge clk) disable iff (!rstN)
    !enableOk |=> (!xferReq && (state == ST_OPEN)));

endmodule

// File: rtl/dmaReqDetect.sv
module dmaReqDetect
  import dmaReqPkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int GUARD_CYCLES = SYNC_STAGES
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] detMode,
  input  logic       overrunSel,
  input  logic       srcPeriph,
  input  logic       chanEn,
  input  logic       masterEn,
  input  logic       xferEnd,
  input  logic       addrErr,
  input  logic       nmiFlag,
  input  logic       extReq,
  input  logic       periphReq,
  input  logic       xferAck,
  output logic       xferReq
);

  ctrlStrobes_t strb;
  logic         hit;
  logic         levelExt;

  dmaReqDatapath #(
    .SYNC_STAGES (SYNC_STAGES),
    .GUARD_CYCLES(GUARD_CYCLES)
  ) uDatapath (
    .clk      (clk),
    .rstN     (rstN),
    .detMode  (detMode),
    .srcPeriph(srcPeriph),
    .extReq   (extReq),
    .periphReq(periphReq),
    .strb     (strb),
    .hit      (hit),
    .levelExt (levelExt)
  );

  dmaReqControl uControl (
    .clk       (clk),
    .rstN      (rstN),
    .overrunSel(overrunSel),
    .chanEn    (chanEn),
    .masterEn  (masterEn),
    .xferEnd   (xferEnd),
    .addrErr   (addrErr),
    .nmiFlag   (nmiFlag),
    .hit       (hit),
    .levelExt  (levelExt),
    .xferAck   (xferAck),
    .strb      (strb),
    .xferReq   (xferReq)
  );

  // R11: in peripheral mode, no strobe means no request on the next cycle
  p_periph_only_r11: assert property (@(posedge clk) disable iff (!rstN)
    (srcPeriph && !periphReq) |=> !xferReq);

endmodule

// File: tb/dmaReqDetect_test.sv
`timescale 1ns/1ps
module dmaReqDetect_test;

  localparam int GUARD = 2;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] detMode = 2'b00;
  logic       overrunSel = 1'b0;
  logic       srcPeriph = 1'b0;
  logic       chanEn = 1'b0;
  logic       masterEn = 1'b1;
  logic       xferEnd = 1'b0;
  logic       addrErr = 1'b0;
  logic       nmiFlag = 1'b0;
  logic       extReq = 1'b1;
  logic       periphReq = 1'b0;
  logic       xferAck = 1'b0;
  logic       xferReq;

  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;
  bit  modelOn = 1'b0;

  always #4 clk = ~clk;

  dmaReqDetect uut (
    .clk(clk), .rstN(rstN), .detMode(detMode), .overrunSel(overrunSel),
    .srcPeriph(srcPeriph), .chanEn(chanEn), .masterEn(masterEn),
    .xferEnd(xferEnd), .addrErr(addrErr), .nmiFlag(nmiFlag),
    .extReq(extReq), .periphReq(periphReq), .xferAck(xferAck),
    .xferReq(xferReq)
  );

  // reference model built from the requirements
  logic mS1, mS2, mPrev, mOpen, mReq;
  int   mGuard;

  function automatic logic extHitOf(logic [1:0] m, logic s, logic p, int g);
    logic lvl;
    lvl = m[1] ? s : !s;
    if (m[0]) return m[1] ? (s & !p) : (!s & p);
    return lvl && (g == 0);
  endfunction

  always @(posedge clk) begin
    logic en, h;
    int   gNext;
    if (!rstN) begin
      mS1 = 1; mS2 = 1; mPrev = 1; mOpen = 1; mReq = 0; mGuard = 0;
    end else begin
      en = chanEn & masterEn & !xferEnd & !addrErr & !nmiFlag;
      h  = srcPeriph ? periphReq : extHitOf(detMode, mS2, mPrev, mGuard);
      gNext = (mGuard != 0) ? mGuard - 1 : 0;
      if (!en) begin
        mOpen = 1; mReq = 0; gNext = 0;
      end else if (mOpen) begin
        mReq = h;
        if (h) mOpen = 0;
      end else begin
        mReq = 0;
        if (xferAck) begin
          mOpen = 1;
          if (!srcPeriph && !detMode[0] && !overrunSel) gNext = GUARD;
        end
      end
      mGuard = gNext; mPrev = mS2; mS2 = mS1; mS1 = extReq;
    end
  end

  always @(negedge clk) begin
    if (modelOn) begin
      checks++;
      if (xferReq !== mReq) begin
        errors++;
        $display("FAIL R6/R7/R10 random: xferReq=%0b expected %0b at %0t", xferReq, mReq, $time);
      end
    end
  end

  task automatic chk(string r, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: xferReq=%0b expected %0b at %0t", r, act, exp, $time);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic stepChk(string r, logic exp);
    @(negedge clk);
    chk(r, xferReq, exp);
  endtask

  task automatic quiet(string r, int n);
    for (int i = 0; i < n; i++) stepChk(r, 1'b0);
  endtask

  task automatic pulseAck(string r);
    xferAck = 1'b1;
    stepChk(r, 1'b0);
    xferAck = 1'b0;
  endtask

  task automatic setup(logic [1:0] m, logic pin, logic ovr, logic src);
    chanEn = 1'b0;
    detMode = m; extReq = pin; overrunSel = ovr; srcPeriph = src;
    cyc(4);
    chanEn = 1'b1;
    cyc(2);
  endtask

  task automatic finishRun();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      finishRun();
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    cyc(3);
    chk("R12 in reset", xferReq, 1'b0);
    rstN = 1'b1;
    chanEn = 1'b1;
    quiet("R12 after reset", 4);

    // R1 low level, R5 latency, R6 pulse
    extReq = 1'b0;
    stepChk("R5 sync 1", 1'b0);
    stepChk("R5 sync 2", 1'b0);
    stepChk("R1 low level", 1'b1);
    stepChk("R6 pulse end", 1'b0);
    quiet("R7 held without ack", 4);
    // R8: level still held after ack, served after guard
    pulseAck("R8 ack cycle");
    stepChk("R8 guard 1", 1'b0);
    stepChk("R8 guard 2", 1'b0);
    stepChk("R8 held level served", 1'b1);
    // R8: level withdrawn together with ack -> no extra
    extReq = 1'b1;
    pulseAck("R8 ack drop");
    quiet("R8 no trailing", 6);

    // R9 overrun plus one
    setup(2'b00, 1'b1, 1'b1, 1'b0);
    extReq = 1'b0;
    cyc(2);
    stepChk("R9 first", 1'b1);
    cyc(2);
    extReq = 1'b1;
    pulseAck("R9 ack");
    stepChk("R9 trailing request", 1'b1);
    cyc(1);
    pulseAck("R9 second ack");
    quiet("R9 only one extra", 5);

    // R3 high level
    setup(2'b10, 1'b0, 1'b0, 1'b0);
    extReq = 1'b1;
    cyc(2);
    stepChk("R3 high level", 1'b1);
    extReq = 1'b0;
    pulseAck("R3 ack");
    quiet("R3 no trailing", 4);

    // R4 rising edge, R7 dropped edge
    setup(2'b11, 1'b0, 1'b0, 1'b0);
    extReq = 1'b1;
    cyc(2);
    stepChk("R4 rising", 1'b1);
    cyc(2);
    pulseAck("R4 ack");
    quiet("R4 held high no repeat", 4);
    extReq = 1'b0;
    cyc(3);
    extReq = 1'b1;
    cyc(2);
    stepChk("R4 second rise", 1'b1);
    extReq = 1'b0;
    cyc(3);
    extReq = 1'b1;
    quiet("R7 edge while waiting", 4);
    pulseAck("R7 ack");
    quiet("R7 dropped edge not queued", 4);
    pulseAck("R7 stray ack");
    quiet("R7 stray ack no effect", 3);

    // R2 falling edge
    setup(2'b01, 1'b1, 1'b0, 1'b0);
    extReq = 1'b0;
    cyc(2);
    stepChk("R2 falling", 1'b1);
    cyc(1);
    pulseAck("R2 ack");
    quiet("R2 held low no repeat", 4);

    // R10 each blocking condition drops an edge
    for (int k = 0; k < 5; k++) begin
      extReq = 1'b1;
      cyc(4);
      case (k)
        0: chanEn = 1'b0;
        1: masterEn = 1'b0;
        2: xferEnd = 1'b1;
        3: addrErr = 1'b1;
        default: nmiFlag = 1'b1;
      endcase
      extReq = 1'b0;
      quiet("R10 blocked edge", 4);
      chanEn = 1'b1; masterEn = 1'b1; xferEnd = 1'b0; addrErr = 1'b0; nmiFlag = 1'b0;
      quiet("R10 edge not kept", 2);
    end
    // R10 pending cleared, held level served without ack
    setup(2'b00, 1'b1, 1'b0, 1'b0);
    extReq = 1'b0;
    cyc(2);
    stepChk("R10 first request", 1'b1);
    cyc(1);
    nmiFlag = 1'b1;
    stepChk("R10 disabled", 1'b0);
    nmiFlag = 1'b0;
    stepChk("R10 re-enabled serves level", 1'b1);
    pulseAck("R10 ack");

    // R11 peripheral source
    setup(2'b00, 1'b0, 1'b0, 1'b1);
    quiet("R11 pin ignored", 4);
    periphReq = 1'b1;
    stepChk("R11 strobe", 1'b1);
    periphReq = 1'b0;
    cyc(1);
    periphReq = 1'b1;
    stepChk("R11 strobe while waiting", 1'b0);
    periphReq = 1'b0;
    pulseAck("R11 ack");
    quiet("R11 strobe not queued", 3);
    periphReq = 1'b1;
    stepChk("R11 second strobe", 1'b1);
    periphReq = 1'b0;
    pulseAck("R11 ack 2");

    // constrained random phase against the model
    modelOn = 1'b1;
    for (int n = 0; n < 4000; n++) begin
      if (n % 250 == 0) begin
        detMode = 2'($urandom_range(0, 3));
        overrunSel = 1'($urandom_range(0, 1));
        srcPeriph = ($urandom_range(0, 3) == 0);
      end
      if ($urandom_range(0, 3) == 0) extReq = ~extReq;
      periphReq = ($urandom_range(0, 7) == 0);
      xferAck = ($urandom_range(0, 3) == 0);
      chanEn = ($urandom_range(0, 31) != 0);
      masterEn = ($urandom_range(0, 63) != 0);
      xferEnd = ($urandom_range(0, 63) == 0);
      addrErr = ($urandom_range(0, 63) == 0);
      nmiFlag = ($urandom_range(0, 63) == 0);
      @(negedge clk);
    end
    modelOn = 1'b0;
    done = 1'b1;
    finishRun();
  end

endmodule